// File: doc/BRIEF.md
# Receive Message Queue with Single Read Window

This block is the receive side of a CAN-style controller, seen from the host. Frames that the bus receiver has finished are pushed in from a frame-side port: a 32-bit identifier word, a 4-bit data length code and eight data bytes. The identifier word is kept exactly as presented, including its extended-format flag (bit 31), its remote-request flag (bit 30) and the identifier field. The block holds up to four frames in arrival order.

The host never addresses individual queue slots. It reads the oldest frame through one fixed window and releases it by writing a key value to a pointer register. A small byte-wide register set covers four functions: turning the queue on, choosing what happens when the queue is full, reporting an empty flag, and keeping the two event flags and the interrupt enable. A reception event drives an interrupt line, and that line can be masked.

Top module: `rx_fifo_window`

## Requirements
- R1: After reset the control register (address 0) reads 0x80: the queue is disabled and the empty flag in bit 7 is set. The status register (address 2) reads 0x00 and `irq` is low.
- R2: Frames stored while the queue is enabled (control bit 0 = 1) are presented on the window in arrival order. The identifier word, the 4-bit length code and the 64 data bits come out unchanged.
- R3: Control bit 7 reads 1 exactly when no frame is held. Host writes to bit 7 have no effect.
- R4: A write of 0xFF to the pointer register (address 1) releases the frame on the window, and the next older frame takes its place. A write of any other value to that register changes nothing.
- R5: A release write while the queue is empty is ignored. A frame pushed afterwards appears on the window and clears the empty flag.
- R6: The queue holds 4 frames. With control bit 3 = 0, a frame that arrives while the queue is full is discarded, the stored frames are unchanged, and no overrun is flagged.
- R7: With control bit 3 = 1, a frame that arrives while the queue is full replaces the most recently stored frame and sets the overrun flag (status bit 5). The three older frames are unchanged.
- R8: While control bit 0 = 0 the queue is emptied and incoming frames are discarded. A frame offered while the queue is disabled is not present after the queue is enabled again.
- R9: Every stored frame sets the receive flag (status bit 4). Writing 0 to status bit 4 or bit 5 clears that bit. Writing 1 leaves it unchanged.
- R10: `irq` is high exactly one cycle after status bit 4 and interrupt-enable bit 4 (address 3) are both set. The overrun flag does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 pointer, 2 status, 3 interrupt enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| rx_valid | input | 1 | Frame push strobe |
| rx_id | input | 32 | Identifier word of the pushed frame |
| rx_dlc | input | 4 | Length code of the pushed frame |
| rx_data | input | 64 | Data bytes of the pushed frame |
| win_id | output | 32 | Identifier word of the oldest frame |
| win_dlc | output | 4 | Length code of the oldest frame |
| win_data | output | 64 | Data bytes of the oldest frame |
| irq | output | 1 | Receive interrupt |

## Verification
A push, a release write or a control write takes effect in the queue state at the clock edge that samples it. The window, `reg_rdata` and `irq` are registered, so they show the result one edge later. Register reads need one more edge for the address to be sampled after that state change. The bench therefore drives inputs on falling edges and samples the window one full cycle after the last push or release. It samples `irq` one cycle after a flag or enable change and reads registers two edges after the stimulus. A scoreboard queue models the four frames and the overwrite rule to predict every window value.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int ID_W   = 32;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
  } rxw_frame_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PTR  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_IEN  = 2'd3;

  localparam int B_ON    = 0;
  localparam int B_OVW   = 3;
  localparam int B_EMPTY = 7;
  localparam int B_RXF   = 4;
  localparam int B_OVF   = 5;

  localparam logic [7:0] POP_KEY = 8'hFF;
endpackage

// File: rtl/rxw_ptrs.sv
module rxw_ptrs #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          ovw_mode,
  input  logic          push,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          is_empty,
  output logic          stored_evt,
  output logic          overrun_evt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic pop_ok, room, push_norm, push_ovw;

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  always_comb begin
    pop_ok    = enable && pop_req && (count != '0);
    room      = (count != FULL_CNT) || pop_ok;
    push_norm = enable && push && room;
    push_ovw  = enable && push && !room && ovw_mode;
    wr_en     = push_norm || push_ovw;
    wr_addr   = push_norm ? wr_ptr : step_down(wr_ptr);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_norm) wr_ptr <= step_up(wr_ptr);
      if (pop_ok)    rd_ptr <= step_up(rd_ptr);
      case ({push_norm, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_addr     = rd_ptr;
  assign is_empty    = (count == '0);
  assign stored_evt  = wr_en;
  assign overrun_evt = push_ovw;

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && push && !pop_req && !ovw_mode && count == FULL_CNT)
      |=> (count == FULL_CNT) && $stable(wr_ptr));
  p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && pop_req && !push && count == '0) |=> $stable(rd_ptr) && count == '0);
  p_disable_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> count == '0);
endmodule

// File: rtl/rxw_store.sv
module rxw_store
  import rxw_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  rxw_frame_t    wr_frame,
  input  logic [AW-1:0] rd_addr,
  output rxw_frame_t    rd_frame
);
  rxw_frame_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_frame;
  end

  always_ff @(posedge clk) begin
    rd_frame <= mem[rd_addr];
  end
endmodule

// File: rtl/rxw_regs.sv
module rxw_regs
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       fifo_empty,
  input  logic       stored_evt,
  input  logic       overrun_evt,
  output logic       enable,
  output logic       ovw_mode,
  output logic       pop_req,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic rx_flag, ovf_flag, rx_ien;
  logic wr_ctrl, wr_stat, wr_ien;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wr_stat = reg_wr && (reg_addr == A_STAT);
    wr_ien  = reg_wr && (reg_addr == A_IEN);
    pop_req = reg_wr && (reg_addr == A_PTR) && (reg_wdata == POP_KEY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      ovw_mode <= 1'b0;
      rx_ien   <= 1'b0;
      rx_flag  <= 1'b0;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        enable   <= reg_wdata[B_ON];
        ovw_mode <= reg_wdata[B_OVW];
      end
      if (wr_ien) rx_ien <= reg_wdata[B_RXF];
      if (stored_evt)                       rx_flag <= 1'b1;
      else if (wr_stat && !reg_wdata[B_RXF]) rx_flag <= 1'b0;
      if (overrun_evt)                      ovf_flag <= 1'b1;
      else if (wr_stat && !reg_wdata[B_OVF]) ovf_flag <= 1'b0;
      irq <= rx_flag && rx_ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h80;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[B_EMPTY] <= fifo_empty;
          reg_rdata[B_OVW]   <= ovw_mode;
          reg_rdata[B_ON]    <= enable;
        end
        A_STAT: begin
          reg_rdata[B_RXF] <= rx_flag;
          reg_rdata[B_OVF] <= ovf_flag;
        end
        A_IEN:   reg_rdata[B_RXF] <= rx_ien;
        default: reg_rdata <= '0;
      endcase
    end
  end

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_ien |=> !irq);
  p_rx_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    stored_evt |=> rx_flag);
  p_ovf_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    overrun_evt |=> ovf_flag);
endmodule

// File: rtl/rx_fifo_window.sv
module rx_fifo_window
  import rxw_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [LEN_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  output logic [ID_W-1:0]   win_id,
  output logic [LEN_W-1:0]  win_dlc,
  output logic [DATA_W-1:0] win_data,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);

  logic          enable, ovw_mode, pop_req, fifo_empty;
  logic          wr_en, stored_evt, overrun_evt;
  logic [AW-1:0] wr_addr, rd_addr;
  rxw_frame_t    in_frame, head;

  assign in_frame = '{id: rx_id, len: rx_dlc, data: rx_data};

  rxw_regs u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fifo_empty(fifo_empty), .stored_evt(stored_evt), .overrun_evt(overrun_evt),
    .enable(enable), .ovw_mode(ovw_mode), .pop_req(pop_req),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  rxw_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst),
    .enable(enable), .ovw_mode(ovw_mode), .push(rx_valid), .pop_req(pop_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .is_empty(fifo_empty),
    .stored_evt(stored_evt), .overrun_evt(overrun_evt)
  );

  rxw_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_frame(in_frame),
    .rd_addr(rd_addr), .rd_frame(head)
  );

  assign win_id   = head.id;
  assign win_dlc  = head.len;
  assign win_data = head.data;

  p_disabled_no_store_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !wr_en);
endmodule

// File: tb/rx_fifo_window_tb.sv
`timescale 1ns/1ps
module rx_fifo_window_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rx_valid = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [31:0] win_id;
  logic [3:0] win_dlc;
  logic [63:0] win_data;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [99:0] exp_q[$];
  bit m_en = 1'b0, m_ovw = 1'b0;

  always #2.5 clk = ~clk;

  rx_fifo_window #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data), .win_id(win_id),
    .win_dlc(win_dlc), .win_data(win_data), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin m_en = d[0]; m_ovw = d[3]; if (!d[0]) exp_q.delete(); end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  // driver: pushes a frame into the DUT and the expected item into the scoreboard
  task automatic push(input logic [31:0] id, input logic [3:0] n, input logic [63:0] d);
    logic [99:0] f;
    f = {id, n, d};
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_dlc = n; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
    if (m_en) begin
      if (exp_q.size() < DEPTH) exp_q.push_back(f);
      else if (m_ovw) exp_q[exp_q.size()-1] = f;
    end
  endtask

  // monitor: compares the window against the scoreboard head, then releases it
  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(req, "scoreboard underflow", 128'd1, 128'd0);
      end else begin
        check(req, "window frame", {28'd0, win_id, win_dlc, win_data}, {28'd0, exp_q[0]});
        void'(exp_q.pop_front());
      end
      wr_reg(2'd1, 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_reg(2'd0, v); check("R1", "ctrl after reset", v, 8'h80);
    rd_reg(2'd2, v); check("R1", "status after reset", v, 8'h00);
    check("R1", "irq after reset", irq, 1'b0);

    wr_reg(2'd0, 8'h01);
    // R2 ordered delivery with flag bits in the id word
    push(32'h8ABC_DEF1, 4'd8, 64'h0102_0304_0506_0708);
    push(32'h4000_0000 | (32'h123 << 18), 4'd0, 64'h0);
    push(32'h1FFF_FFFF, 4'd15, 64'hFFEE_DDCC_BBAA_9988);
    drain(3, "R2");
    // R3 empty flag
    rd_reg(2'd0, v); check("R3", "empty after drain", v, 8'h81);
    push(32'h0000_0055, 4'd2, 64'hAA55);
    wr_reg(2'd0, 8'h81);
    rd_reg(2'd0, v); check("R3", "bit7 write ignored, not empty", v, 8'h01);
    // R4 non-key value does not release
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd1, 8'hFE);
    drain(1, "R4");
    rd_reg(2'd0, v); check("R4", "key release emptied queue", v, 8'h81);
    // R5 release while empty is ignored
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    push(32'h0000_0777, 4'd3, 64'h777);
    rd_reg(2'd0, v); check("R5", "not empty after push", v, 8'h01);
    drain(1, "R5");
    // R6 full queue drops newcomer in mode 0
    wr_reg(2'd2, 8'h00);
    for (int i = 0; i < 5; i++) push(32'h100 + i, 4'(i), 64'(i * 3 + 1));
    rd_reg(2'd2, v); check("R6", "no overrun flag", v, 8'h10);
    drain(4, "R6");
    rd_reg(2'd0, v); check("R6", "empty after four", v, 8'h81);
    // R7 overwrite newest in mode 1
    wr_reg(2'd0, 8'h09);
    for (int i = 0; i < 5; i++) push(32'h200 + i, 4'(i + 1), 64'(i * 7 + 2));
    rd_reg(2'd2, v); check("R7", "overrun flag set", v, 8'h30);
    drain(4, "R7");
    rd_reg(2'd0, v); check("R7", "empty after four", v, 8'h89);
    // R8 disable clears and drops
    wr_reg(2'd0, 8'h01);
    push(32'h300, 4'd1, 64'h3);
    push(32'h301, 4'd1, 64'h4);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v); check("R8", "disabled reads empty", v, 8'h80);
    push(32'h302, 4'd1, 64'h5);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd0, v); check("R8", "still empty after enable", v, 8'h81);
    // R9 flag write semantics
    wr_reg(2'd2, 8'h00);
    push(32'h400, 4'd4, 64'h44);
    rd_reg(2'd2, v); check("R9", "rx flag set", v, 8'h10);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); check("R9", "write 1 keeps flag", v, 8'h10);
    // R10 interrupt gating
    @(negedge clk); check("R10", "irq masked", irq, 1'b0);
    wr_reg(2'd3, 8'h10);
    @(negedge clk); check("R10", "irq enabled", irq, 1'b1);
    wr_reg(2'd2, 8'h00);
    @(negedge clk); check("R10", "irq after clear", irq, 1'b0);
    rd_reg(2'd2, v); check("R9", "write 0 clears flag", v, 8'h00);
    wr_reg(2'd0, 8'h09);
    for (int i = 0; i < 4; i++) push(32'h500 + i, 4'd1, 64'(i));
    wr_reg(2'd2, 8'h20);
    @(negedge clk); check("R10", "rx cleared, no irq", irq, 1'b0);
    push(32'h600, 4'd1, 64'h6);
    rd_reg(2'd2, v); check("R10", "overrun with rx flag", v, 8'h30);
    wr_reg(2'd2, 8'h20);
    @(negedge clk); check("R10", "overrun flag alone keeps irq low", irq, 1'b0);
    drain(4, "R7");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule